// File: doc/BRIEF.md
# Interleaved SEC-DED Word Memory with Scrub

This block is a small on-chip word memory whose contents are guarded by an extended Hamming code. Each write encodes the data word into a codeword (data plus Hamming check bits plus one overall parity bit) and stores it. Each read decodes the stored codeword. A single flipped cell is repaired in the data returned to the reader and reported with a correction flag. A double flip is reported as uncorrectable and is not altered.

The storage cells of the codewords are spread across a bit-interleaved array. Several logical words share one physical row, and the cells of one word lie a fixed stride apart. A strike that upsets a short run of neighbouring cells therefore lands as single errors in different words, and each of those errors can be repaired.

A repair only fixes the outgoing copy. So whenever a read reports a correction, the block rewrites the repaired word, with freshly computed check bits, into its own location. It does this in the same cycle that the read data is presented. It holds `busy` high for that cycle so that no new request is taken. A test input inverts a short run of physical cells in one row, so that upsets can be produced on demand.

Top module: `ilv_secded_mem`

## Requirements
- R1: A write accepted at a clock edge stores its data. A read accepted at an edge presents `rd_valid`=1 and the stored data throughout the following cycle, with both flags low when no cell of that word is flipped. An accepted write never raises `rd_valid`, and back-to-back clean reads are accepted on consecutive cycles.
- R2: Word address `a` lives in physical row `a/4` at word slot `a%4`. Codeword bit `b` of that word sits in physical column `b*4 + a%4` (13 codeword bits, 52 columns per row). Codeword bit 0 is the overall parity bit. Bits 1, 2, 4 and 8 are Hamming check bits. Data bits 0 to 7 sit in that order at codeword bits 3, 5, 6, 7, 9, 10, 11 and 12.
- R3: A read of a word with exactly one flipped data cell returns the original data with `rd_corrected`=1 and `rd_uncorrectable`=0.
- R4: A read of a word whose only flipped cell is a check or parity cell returns the unchanged data with `rd_corrected`=1.
- R5: A flipped cell stays in the array while other words are read or written. A read of its own word repairs only the returned copy.
- R6: In the cycle that presents a corrected read, `busy` is 1 and the repaired word is rewritten. The next read of that word is clean, and `busy` never stays high for two cycles in a row.
- R7: A request presented while `busy` is 1 is ignored. An ignored write leaves the addressed word unchanged.
- R8: A run of up to 4 adjacent flipped cells in one row touches each word at most once, and a read of each touched word reports a correction with the original data.
- R9: A read of a word with two flipped cells sets `rd_uncorrectable`=1 and `rd_corrected`=0, keeps `busy` low and writes nothing back, so a second read reports the same. The two flags are never high together.
- R10: A write to a word with flipped cells replaces all of its cells, and the next read of that word is clean.
- R11: Injection inverts `inj_len` cells starting at column `inj_col` of row `inj_row`. A length of 0 changes nothing. Columns past 51 are not touched. An injection in the same cycle as a write or rewrite of the same cells is applied after that write.
- R12: While `rst` is high and in the first cycle after it, `busy`, `rd_valid`, `rd_corrected` and `rd_uncorrectable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Rewrite of a repaired word in progress; requests are ignored |
| rd_valid | output | 1 | Read result presented this cycle |
| rd_data | output | 8 | Read data after repair |
| rd_corrected | output | 1 | A single flipped cell was repaired |
| rd_uncorrectable | output | 1 | Two flipped cells detected; data not repaired |
| inj_en | input | 1 | Apply a cell-inversion run this cycle |
| inj_row | input | 2 | Physical row of the run |
| inj_col | input | 6 | First physical column of the run |
| inj_len | input | 3 | Number of cells to invert, 0 to 4 |

## Verification
Two pairs of functions can land on the same edge. The first pair is the rewrite of a repaired word and a fault injection into that same word. The bench provokes it by injecting into the repaired word during its `busy` cycle. It then expects the following read to report a fresh correction, because the injection is applied after the rewrite. The second pair is the rewrite and a new request. The bench provokes it by presenting a write during `busy` and judges it by reading that address back with its old data. The same kind of overlap between a write and an injection into the written word is judged in the same way. All of these judgements come from a behavioural model that tracks the data and a flip mask for each word.

// File: rtl/ilv_secded_pkg.sv
package ilv_secded_pkg;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int check_bits(input int dw);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 31;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Codeword position of data bit i: the i-th position that is not a power of two.
  function automatic int data_pos(input int i);
    int n;
    n = 0;
    for (int pos = 1; pos < 1024; pos++) begin
      if (!is_pow2(pos)) begin
        if (n == i) return pos;
        n++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/secded_encode.sv
module secded_encode
  import ilv_secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P = check_bits(DATA_W),
  localparam int CODE_W = DATA_W + P + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] c;
  logic              par;

  always_comb begin
    c = '0;
    for (int i = 0; i < DATA_W; i++) c[data_pos(i)] = data[i];
    // Check bit at position 2^k covers every position with bit k set.
    for (int k = 0; k < P; k++) begin
      par = 1'b0;
      for (int pos = 1; pos < CODE_W; pos++) begin
        if ((((pos >> k) & 1) == 1) && (pos != (1 << k))) par = par ^ c[pos];
      end
      c[1 << k] = par;
    end
    // Overall parity over the whole codeword lives in position 0.
    c[0] = ^c;
    code = c;
  end

endmodule

// File: rtl/secded_decode.sv
module secded_decode
  import ilv_secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P = check_bits(DATA_W),
  localparam int CODE_W = DATA_W + P + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              uncorrectable
);

  logic [P-1:0]      syn;
  logic              ovr;
  logic [CODE_W-1:0] fix;

  always_comb begin
    syn = '0;
    for (int k = 0; k < P; k++) begin
      for (int pos = 1; pos < CODE_W; pos++) begin
        if (((pos >> k) & 1) == 1) syn[k] = syn[k] ^ code[pos];
      end
    end
    ovr           = ^code;
    fix           = code;
    corrected     = 1'b0;
    uncorrectable = 1'b0;
    if (ovr) begin
      // Odd number of flips: one error. Zero syndrome means the parity cell itself.
      corrected = 1'b1;
      if (syn != '0) begin
        if (int'(syn) < CODE_W) begin
          for (int pos = 1; pos < CODE_W; pos++) begin
            if (pos == int'(syn)) fix[pos] = ~fix[pos];
          end
        end else begin
          corrected     = 1'b0;
          uncorrectable = 1'b1;
        end
      end
    end else if (syn != '0) begin
      // Even flips with a nonzero syndrome: double error, leave it alone.
      uncorrectable = 1'b1;
    end
    for (int i = 0; i < DATA_W; i++) data[i] = fix[data_pos(i)];
  end

endmodule

// File: rtl/ilv_cell_array.sv
module ilv_cell_array #(
  parameter int CODE_W    = 13,
  parameter int ILV       = 4,
  parameter int ROWS      = 4,
  parameter int MAX_BURST = 4,
  localparam int ROW_W = CODE_W * ILV,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int OW    = (ILV > 1) ? $clog2(ILV) : 1,
  localparam int CW    = $clog2(ROW_W),
  localparam int LW    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_row,
  input  logic [OW-1:0]     wr_off,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              rd_en,
  input  logic [RW-1:0]     rd_row,
  input  logic [OW-1:0]     rd_off,
  input  logic              inj_en,
  input  logic [RW-1:0]     inj_row,
  input  logic [CW-1:0]     inj_col,
  input  logic [LW-1:0]     inj_len,
  output logic [CODE_W-1:0] rd_code
);

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] nxt [ROWS];
  logic [ROW_W-1:0] wmask, wval, imask, row_q;
  logic [OW-1:0]    off_q;

  // Spread the codeword over the row: bit b goes to column b*ILV + slot.
  always_comb begin
    wmask = '0;
    wval  = '0;
    for (int b = 0; b < CODE_W; b++) begin
      for (int o = 0; o < ILV; o++) begin
        if (o == int'(wr_off)) begin
          wmask[b*ILV + o] = 1'b1;
          wval[b*ILV + o]  = wr_code[b];
        end
      end
    end
  end

  // Inversion run, clipped at the end of the row.
  always_comb begin
    for (int c = 0; c < ROW_W; c++) begin
      imask[c] = inj_en && (c >= int'(inj_col)) && (c < int'(inj_col) + int'(inj_len));
    end
  end

  // Write first, then the injection on top of the result.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      nxt[r] = mem[r];
      if (wr_en && (int'(wr_row) == r)) nxt[r] = (nxt[r] & ~wmask) | (wval & wmask);
      if (int'(inj_row) == r) nxt[r] = nxt[r] ^ imask;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) mem[r] <= nxt[r];
    if (rd_en) begin
      row_q <= mem[rd_row];
      off_q <= rd_off;
    end
  end

  // Gather the addressed word back out of the latched row.
  always_comb begin
    for (int b = 0; b < CODE_W; b++) begin
      rd_code[b] = 1'b0;
      for (int o = 0; o < ILV; o++) begin
        if (o == int'(off_q)) rd_code[b] = row_q[b*ILV + o];
      end
    end
  end

endmodule

// File: rtl/ilv_secded_mem.sv
module ilv_secded_mem
  import ilv_secded_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int ILV       = 4,
  parameter int MAX_BURST = 4,
  localparam int P      = check_bits(DATA_W),
  localparam int CODE_W = DATA_W + P + 1,
  localparam int ROWS   = DEPTH / ILV,
  localparam int ROW_W  = CODE_W * ILV,
  localparam int AW     = $clog2(DEPTH),
  localparam int OW     = (ILV > 1) ? $clog2(ILV) : 1,
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW     = $clog2(ROW_W),
  localparam int LW     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable,
  input  logic              inj_en,
  input  logic [RW-1:0]     inj_row,
  input  logic [CW-1:0]     inj_col,
  input  logic [LW-1:0]     inj_len
);

  logic              accept, rd_acc, wr_acc;
  logic              rd_valid_q;
  logic [AW-1:0]     rd_addr_q;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] enc_in;
  logic [CODE_W-1:0] enc_code, arr_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr, dec_unc;

  assign accept = req_valid && !busy;
  assign rd_acc = accept && !req_write;
  assign wr_acc = accept && req_write;

  // One encoder shared: the rewrite cycle owns the port, so no request competes.
  assign enc_in  = busy ? dec_data : req_wdata;
  assign wr_addr = busy ? rd_addr_q : req_addr;

  secded_encode #(.DATA_W(DATA_W)) u_enc (
    .data (enc_in),
    .code (enc_code)
  );

  ilv_cell_array #(
    .CODE_W    (CODE_W),
    .ILV       (ILV),
    .ROWS      (ROWS),
    .MAX_BURST (MAX_BURST)
  ) u_array (
    .clk     (clk),
    .wr_en   (busy || wr_acc),
    .wr_row  (wr_addr[AW-1:OW]),
    .wr_off  (wr_addr[OW-1:0]),
    .wr_code (enc_code),
    .rd_en   (rd_acc),
    .rd_row  (req_addr[AW-1:OW]),
    .rd_off  (req_addr[OW-1:0]),
    .inj_en  (inj_en),
    .inj_row (inj_row),
    .inj_col (inj_col),
    .inj_len (inj_len),
    .rd_code (arr_code)
  );

  secded_decode #(.DATA_W(DATA_W)) u_dec (
    .code          (arr_code),
    .data          (dec_data),
    .corrected     (dec_corr),
    .uncorrectable (dec_unc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_valid_q <= rd_acc;
      if (rd_acc) rd_addr_q <= req_addr;
    end
  end

  assign rd_valid         = rd_valid_q;
  assign rd_data          = dec_data;
  assign rd_corrected     = rd_valid_q && dec_corr;
  assign rd_uncorrectable = rd_valid_q && dec_unc;
  assign busy             = rd_valid_q && dec_corr;

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_corrected && rd_uncorrectable));

  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !busy) |=> rd_valid);

  a_r1_write_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !busy) |=> !rd_valid);

  a_r6_scrub_single_cycle: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

endmodule

// File: tb/ilv_secded_mem_bench.sv
module ilv_secded_mem_bench;

  localparam int CELLS = 52;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       busy, rd_valid, rd_corrected, rd_uncorrectable;
  logic [7:0] rd_data;
  logic       inj_en = 1'b0;
  logic [1:0] inj_row = '0;
  logic [5:0] inj_col = '0;
  logic [2:0] inj_len = '0;

  always #5 clk = ~clk;

  ilv_secded_mem u_ilv_secded_mem (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .busy (busy), .rd_valid (rd_valid), .rd_data (rd_data),
    .rd_corrected (rd_corrected), .rd_uncorrectable (rd_uncorrectable),
    .inj_en (inj_en), .inj_row (inj_row), .inj_col (inj_col), .inj_len (inj_len)
  );

  int n_checks = 0, n_errs = 0;
  string cur_req = "R1";
  int dpos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  // Behavioural model: golden data and flip mask per word.
  logic [7:0]  gd [16];
  logic [12:0] fm [16];
  bit          m_valid = 0, m_busy = 0;
  int          m_cnt = 0, m_addr = 0;
  logic [7:0]  m_data = '0;
  string       m_tag = "R1";
  bit          acc, nv;
  int          a, s_cnt, s_addr, cc;
  logic [7:0]  s_data;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_busy = 0; m_cnt = 0;
      for (int w = 0; w < 16; w++) begin fm[w] = '0; gd[w] = '0; end
    end else begin
      acc = req_valid && !m_busy;
      a   = int'(req_addr);
      nv  = acc && !req_write;
      s_cnt = 0; s_addr = 0; s_data = '0;
      if (nv) begin
        s_cnt = $countones(fm[a]); s_data = gd[a]; s_addr = a;
      end
      if (m_busy) fm[m_addr] = '0;
      if (acc && req_write) begin gd[a] = req_wdata; fm[a] = '0; end
      if (inj_en) begin
        for (int j = 0; j < int'(inj_len); j++) begin
          cc = int'(inj_col) + j;
          if (cc < CELLS) fm[int'(inj_row)*4 + cc%4][cc/4] ^= 1'b1;
        end
      end
      m_valid = nv;
      if (nv) begin m_cnt = s_cnt; m_data = s_data; m_addr = s_addr; m_tag = cur_req; end
      m_busy = nv && (s_cnt == 1);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_valid === m_valid, m_tag, "rd_valid", int'(rd_valid), int'(m_valid));
      chk(busy === m_busy, m_tag, "busy", int'(busy), int'(m_busy));
      chk(rd_corrected === (m_valid && m_cnt == 1), m_tag, "rd_corrected",
          int'(rd_corrected), int'(m_valid && m_cnt == 1));
      chk(rd_uncorrectable === (m_valid && m_cnt >= 2), m_tag, "rd_uncorrectable",
          int'(rd_uncorrectable), int'(m_valid && m_cnt >= 2));
      if (m_valid && m_cnt <= 1)
        chk(rd_data === m_data, m_tag, "rd_data", int'(rd_data), int'(m_data));
    end
  end

  task automatic op(input bit rv, input bit we, input int ad, input int d,
                    input bit ie, input int ir, input int ic, input int il,
                    input string tag);
    cur_req   = tag;
    req_valid = rv; req_write = we;
    req_addr  = 4'(ad); req_wdata = 8'(d);
    inj_en    = ie; inj_row = 2'(ir); inj_col = 6'(ic); inj_len = 3'(il);
    @(negedge clk);
    req_valid = 1'b0; inj_en = 1'b0;
  endtask

  task automatic wr(input int ad, input int d, input string tag);
    op(1, 1, ad, d, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input int ad, input string tag);
    op(1, 0, ad, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, cur_req);
  endtask
  // Flip codeword bit b of word w (R2 mapping).
  task automatic flip(input int w, input int b, input string tag);
    op(0, 0, 0, 0, 1, w/4, b*4 + w%4, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !rd_corrected && !rd_uncorrectable, "R12",
        "reset outputs", int'({busy, rd_valid, rd_corrected, rd_uncorrectable}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_valid, "R12", "post-reset outputs", int'({busy, rd_valid}), 0);

    // R1: fill and read back clean, back to back.
    for (int w = 0; w < 16; w++) wr(w, ((w*29 + 7) & 255) ^ 8'hA5, "R1");
    for (int w = 0; w < 16; w++) rd(w, "R1");
    idle();

    // R2/R3: single data cell flip in word 6, data bit 5.
    flip(6, dpos[5], "R3");
    rd(6, "R3"); idle();
    rd(6, "R6"); idle();

    // R5: flip persists across other traffic.
    flip(9, dpos[0], "R5");
    rd(8, "R5"); wr(11, 8'h3C, "R5"); rd(10, "R5"); idle(); idle();
    rd(9, "R5"); idle();
    rd(9, "R6"); idle();

    // R4: parity cell and a check cell.
    flip(15, 0, "R4");
    rd(15, "R4"); idle();
    flip(12, 4, "R4");
    rd(12, "R4"); idle();

    // R8: burst of 4 adjacent cells in row 0 at data bit 2 position.
    op(0, 0, 0, 0, 1, 0, dpos[2]*4, 4, "R8");
    rd(0, "R8"); rd(1, "R8"); rd(2, "R8"); rd(3, "R8"); idle();
    rd(1, "R8"); idle();

    // R9: two flips in word 4, then R10 rewrite.
    flip(4, dpos[0], "R9");
    flip(4, dpos[3], "R9");
    rd(4, "R9"); idle(); rd(4, "R9"); idle();
    wr(4, 8'h5A, "R10");
    rd(4, "R10"); idle();

    // R7: write presented during the rewrite cycle is ignored.
    flip(5, dpos[6], "R7");
    rd(5, "R7");
    wr(13, 8'hEE, "R7");
    rd(13, "R7"); idle();

    // R11: injection into the word being rewritten survives the rewrite.
    flip(5, dpos[1], "R11");
    rd(5, "R11");
    op(0, 0, 0, 0, 1, 1, dpos[4]*4 + 1, 1, "R11");
    rd(5, "R11"); idle();
    rd(5, "R11"); idle();

    // R11: zero length does nothing; run clipped at row end.
    op(0, 0, 0, 0, 1, 0, 0, 0, "R11");
    rd(0, "R11");
    op(0, 0, 0, 0, 1, 3, 50, 4, "R11");
    rd(12, "R11"); rd(13, "R11"); rd(14, "R11"); rd(15, "R11"); idle();

    // R11: injection in the same cycle as a write to the same word.
    op(1, 1, 7, 8'h81, 1, 1, dpos[7]*4 + 3, 1, "R11");
    rd(7, "R11"); idle();
    rd(7, "R10"); idle();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog R1 actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule